// File: doc/BRIEF.md
# Fractional Synthesizer Output Channel

This block is one output channel of a digital frequency synthesizer. It runs on a fast reference clock. Each time an output period completes, it raises a one-cycle clock-enable pulse, `tick_o`. The period is set by four fields:

- a 5-bit coarse divider `md`
- a 15-bit fine phase step `pe`
- a 4-bit power-of-two post-divider exponent `sdiv`
- a divide-by-3 select bit

A fractional phase accumulator adds 2^20 each running cycle and wraps modulo `(32+md)*2^15 + pe`. A post-divider then counts `2^sdiv * ns` accumulator wraps per output pulse. The output rate is therefore `fin*32*2^20 / ((2^20*(32+md) + 32*pe) * 2^sdiv * ns)`.

Software writes the four fields into a parameter register through a small write port. They only reach the running datapath when the load bit of the control register goes from 0 to 1. The new set then waits in a pending buffer until the current output period ends, so no output period is cut short. A control register also provides:

- an active-low standby bit, which freezes the channel;
- a channel hold bit, which clears the phase and is written 0 to release.

Four such channels can share one reference clock, each with its own instance.

Top module: `fsyn_channel`

## Requirements
- R1: The parameter word at write address 1 holds `md` in bits [4:0], `pe` in [19:5], `sdiv` in [23:20] and the divide-by-3 select in bit 24. After a fresh start, output pulse n (n >= 1) is registered exactly ceil(n*L*M / 2^20) cycles after the start, where M = (32+md)*32768 + pe and L = 2^sdiv * ns.
- R2: ns is 3 when the select bit is 0 and 1 when it is 1.
- R3: The control word at write address 0 has load in bit 0, awake in bit 1 and hold in bit 2. A parameter write has no effect on the running output unless a later control write changes the load bit from 0 to 1. Rewriting load=1 while it is already 1 loads nothing.
- R4: While the channel runs, a loaded parameter set takes effect at the end of the current output period. That period keeps its full length, and the next period follows the new set from a cleared phase.
- R5: While awake is 0 and hold is 0, `tick_o` stays low and the accumulator and post-divider keep their state. Resuming adds exactly the frozen cycles to the interrupted period.
- R6: While hold is 1, `tick_o` stays low and the phase is cleared. After hold is written 0, the first pulse follows R1 counted from that write. The reset value of hold is 1.
- R7: When the active `md`, `pe` and `sdiv` are all zero, `unprog_o` is 1 and `tick_o` stays low. A loaded set is applied immediately while the channel is held, in standby or unprogrammed.
- R8: After reset, `tick_o` is 0 and `unprog_o` is 1.
- R9: The accumulator always stays below its modulus, and every pulse follows an accumulator wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 selects the parameter word |
| wr_data | input | 25 | Write data |
| tick_o | output | 1 | Registered one-cycle output clock enable |
| unprog_o | output | 1 | Active parameter set is all zero in md, pe and sdiv |

## Verification
The bench measures exact cycle distances between pulses for fractional and integer settings, with and without divide-by-3. A wrong modulus, step or rounding would shift these counts by one or more cycles.

A retune is applied in the middle of a period. A design that switched parameters at once, instead of at the period end, would shorten that period. Parameter writes made with the load bit low or held high must leave the period unchanged; a design that leaked shadow writes would show the new period.

Standby is expected to extend the interrupted period by exactly its length. A design that cleared the phase there would give a different interval. A hold release is expected to restart from zero phase, so a stale residue would move the first pulse.

// File: rtl/fsyn_pkg.sv
`timescale 1ns/1ps
package fsyn_pkg;
  // write address decode
  localparam logic ADR_CTRL  = 1'b0;
  localparam logic ADR_PARAM = 1'b1;
  // control word bit positions
  localparam int CB_LOAD  = 0;
  localparam int CB_AWAKE = 1;
  localparam int CB_HOLD  = 2;

  typedef struct packed {
    logic hold;
    logic awake;
    logic load;
  } ctl_t;
endpackage

// File: rtl/fsyn_regs.sv
`timescale 1ns/1ps
module fsyn_regs
  import fsyn_pkg::*;
#(
  parameter int MD_W = 5,
  parameter int PE_W = 15,
  parameter int SD_W = 4,
  localparam int PW  = MD_W + PE_W + SD_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [PW-1:0]   wr_data,
  output logic            hold_o,
  output logic            awake_o,
  output logic            ld_pulse_o,
  output logic [MD_W-1:0] md_o,
  output logic [PE_W-1:0] pe_o,
  output logic [SD_W-1:0] sd_o,
  output logic            byp_o
);
  ctl_t ctl_q;
  logic ctl_wr;
  logic par_wr;

  assign ctl_wr = wr_en && (wr_addr == ADR_CTRL);
  assign par_wr = wr_en && (wr_addr == ADR_PARAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '{hold: 1'b1, awake: 1'b0, load: 1'b0};
      ld_pulse_o <= 1'b0;
      md_o       <= '0;
      pe_o       <= '0;
      sd_o       <= '0;
      byp_o      <= 1'b0;
    end else begin
      // a load request exists only on a 0 -> 1 change of the load bit
      ld_pulse_o <= ctl_wr && wr_data[CB_LOAD] && !ctl_q.load;
      if (ctl_wr) begin
        ctl_q.load  <= wr_data[CB_LOAD];
        ctl_q.awake <= wr_data[CB_AWAKE];
        ctl_q.hold  <= wr_data[CB_HOLD];
      end
      if (par_wr) begin
        md_o  <= wr_data[0 +: MD_W];
        pe_o  <= wr_data[MD_W +: PE_W];
        sd_o  <= wr_data[MD_W + PE_W +: SD_W];
        byp_o <= wr_data[PW-1];
      end
    end
  end

  assign hold_o  = ctl_q.hold;
  assign awake_o = ctl_q.awake;
endmodule

// File: rtl/fsyn_active_stage.sv
`timescale 1ns/1ps
module fsyn_active_stage #(
  parameter int MD_W = 5,
  parameter int PE_W = 15,
  parameter int SD_W = 4,
  localparam int PW  = MD_W + PE_W + SD_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_pulse,
  input  logic [MD_W-1:0] md_s,
  input  logic [PE_W-1:0] pe_s,
  input  logic [SD_W-1:0] sd_s,
  input  logic            byp_s,
  input  logic            idle,
  input  logic            period_end,
  output logic            apply_o,
  output logic [MD_W-1:0] md_a,
  output logic [PE_W-1:0] pe_a,
  output logic [SD_W-1:0] sd_a,
  output logic            byp_a
);
  logic [PW-1:0] shadow_w;
  logic [PW-1:0] pbuf_q;
  logic [PW-1:0] act_q;
  logic          pend_q;

  assign shadow_w = {byp_s, sd_s, pe_s, md_s};
  // switch only when nothing runs or when the running period just ended
  assign apply_o  = pend_q && (idle || period_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      pbuf_q <= '0;
      act_q  <= '0;
    end else begin
      if (ld_pulse) begin
        pend_q <= 1'b1;
        pbuf_q <= shadow_w;
      end else if (apply_o) begin
        pend_q <= 1'b0;
      end
      if (apply_o) act_q <= pbuf_q;
    end
  end

  assign {byp_a, sd_a, pe_a, md_a} = act_q;
endmodule

// File: rtl/fsyn_phase_acc.sv
`timescale 1ns/1ps
module fsyn_phase_acc #(
  parameter int MD_W  = 5,
  parameter int PE_W  = 15,
  localparam int ACC_W = MD_W + PE_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [MD_W-1:0]  md,
  input  logic [PE_W-1:0]  pe,
  output logic             wrap_o,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] mod_o
);
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << (MD_W + PE_W);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_w;
  logic [ACC_W-1:0] coarse_w;

  // modulus = (2^MD_W + md) * 2^PE_W + pe
  assign coarse_w = {{(PE_W + 1){1'b0}}, 1'b1, md};
  assign mod_o    = (coarse_w << PE_W) + {{(MD_W + 2){1'b0}}, pe};
  assign sum_w    = acc_q + STEP;
  assign wrap_o   = run && (sum_w >= mod_o);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
    end else if (run) begin
      acc_q <= wrap_o ? (sum_w - mod_o) : sum_w;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/fsyn_post_div.sv
`timescale 1ns/1ps
module fsyn_post_div #(
  parameter int SD_W     = 4,
  parameter bit HAS_DIV3 = 1'b1,
  localparam int CNT_W   = (1 << SD_W) + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            step,
  input  logic [SD_W-1:0] sdiv,
  input  logic            byp,
  output logic            last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mult_w;
  logic [CNT_W-1:0] len_w;

  generate
    if (HAS_DIV3) begin : g_div3
      // select bit low means divide by 3
      assign mult_w = byp ? CNT_W'(1) : CNT_W'(3);
    end else begin : g_nodiv3
      assign mult_w = CNT_W'(1);
    end
  endgenerate

  assign len_w  = mult_w << sdiv;
  assign last_o = step && (cnt_q == len_w - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fsyn_channel.sv
`timescale 1ns/1ps
module fsyn_channel #(
  parameter int MD_W     = 5,
  parameter int PE_W     = 15,
  parameter int SD_W     = 4,
  parameter bit HAS_DIV3 = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       wr_addr,
  input  logic [MD_W+PE_W+SD_W:0]    wr_data,
  output logic                       tick_o,
  output logic                       unprog_o
);
  localparam int ACC_W = MD_W + PE_W + 2;
  localparam int ACT_W = MD_W + PE_W + SD_W + 1;

  logic            hold_w, awake_w, ld_w;
  logic [MD_W-1:0] md_s, md_a;
  logic [PE_W-1:0] pe_s, pe_a;
  logic [SD_W-1:0] sd_s, sd_a;
  logic            byp_s, byp_a;
  logic            run_w, apply_w, wrap_w, last_w, clr_w;
  logic [ACC_W-1:0] acc_w, mod_w;
  logic            tick_q;

  fsyn_regs #(.MD_W(MD_W), .PE_W(PE_W), .SD_W(SD_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hold_o(hold_w), .awake_o(awake_w), .ld_pulse_o(ld_w),
    .md_o(md_s), .pe_o(pe_s), .sd_o(sd_s), .byp_o(byp_s)
  );

  fsyn_active_stage #(.MD_W(MD_W), .PE_W(PE_W), .SD_W(SD_W)) u_stage (
    .clk(clk), .rst(rst), .ld_pulse(ld_w),
    .md_s(md_s), .pe_s(pe_s), .sd_s(sd_s), .byp_s(byp_s),
    .idle(!run_w), .period_end(last_w), .apply_o(apply_w),
    .md_a(md_a), .pe_a(pe_a), .sd_a(sd_a), .byp_a(byp_a)
  );

  assign unprog_o = (md_a == '0) && (pe_a == '0) && (sd_a == '0);
  assign run_w    = awake_w && !hold_w && !unprog_o;
  assign clr_w    = hold_w || apply_w;

  fsyn_phase_acc #(.MD_W(MD_W), .PE_W(PE_W)) u_acc (
    .clk(clk), .rst(rst), .run(run_w), .clear(clr_w),
    .md(md_a), .pe(pe_a), .wrap_o(wrap_w), .acc_o(acc_w), .mod_o(mod_w)
  );

  fsyn_post_div #(.SD_W(SD_W), .HAS_DIV3(HAS_DIV3)) u_div (
    .clk(clk), .rst(rst), .clear(clr_w), .step(wrap_w),
    .sdiv(sd_a), .byp(byp_a), .last_o(last_w)
  );

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= last_w;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/fsyn_channel_chk.sv
`timescale 1ns/1ps
module fsyn_channel_chk #(
  parameter int ACC_W = 22,
  parameter int ACT_W = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_o,
  input logic             unprog_o,
  input logic             hold,
  input logic             awake,
  input logic             apply,
  input logic             wrap,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] modulus,
  input logic [ACT_W-1:0] act
);
  p_tick_after_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(wrap));
  p_acc_bound_r9: assert property (@(posedge clk) disable iff (rst)
    acc < modulus);
  p_act_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(act));
  p_apply_restart_r4: assert property (@(posedge clk) disable iff (rst)
    apply |=> (acc == '0));
  p_standby_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !awake |=> !tick_o);
  p_standby_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!hold && !awake && !apply) |=> $stable(acc));
  p_hold_clear_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> (acc == '0) && !tick_o);
  p_unprog_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    unprog_o |=> !tick_o);
endmodule

bind fsyn_channel fsyn_channel_chk #(.ACC_W(ACC_W), .ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_o(tick_o), .unprog_o(unprog_o),
  .hold(hold_w), .awake(awake_w), .apply(apply_w), .wrap(wrap_w),
  .acc(acc_w), .modulus(mod_w), .act({byp_a, sd_a, pe_a, md_a})
);

// File: tb/fsyn_channel_tb.sv
`timescale 1ns/1ps
module fsyn_channel_tb;
  typedef struct packed {
    logic [4:0]  md;
    logic [14:0] pe;
    logic [3:0]  sd;
    logic        byp;
    logic [7:0]  k;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  15'd0,     4'd1, 1'b1, 8'd20},
    '{5'd31, 15'd0,     4'd0, 1'b1, 8'd40},
    '{5'd5,  15'd1000,  4'd2, 1'b0, 8'd10},
    '{5'd0,  15'd32767, 4'd3, 1'b1, 8'd10},
    '{5'd16, 15'd12345, 4'd0, 1'b0, 8'd30},
    '{5'd7,  15'd3,     4'd8, 1'b0, 8'd3},
    '{5'd1,  15'd0,     4'd0, 1'b0, 8'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [24:0] wr_data = '0;
  logic        tick_o, unprog_o;
  int cyc = 0;
  int total = 0;
  int bad = 0;
  int last_edge = 0;

  fsyn_channel u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_o(tick_o), .unprog_o(unprog_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint cdiv(longint a, longint b);
    return (a + b - 1) / b;
  endfunction

  // L*M product from the rate equation
  function automatic longint lm(logic [4:0] md, logic [14:0] pe, logic [3:0] sd, logic byp);
    longint l = (byp ? 64'd1 : 64'd3) << sd;
    longint m = (64'd32 + md) * 64'd32768 + pe;
    return l * m;
  endfunction

  function automatic logic [24:0] pword(logic [4:0] md, logic [14:0] pe, logic [3:0] sd, logic byp);
    return {byp, sd, pe, md};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [24:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    last_edge = cyc;
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input logic ld, input logic aw, input logic hd);
    wr(1'b0, {22'd0, hd, aw, ld});
  endtask

  task automatic wait_tick(input string req, output int e);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_o && n < 20000);
    if (!tick_o) chk(req, 0, 1, "pulse timeout");
    e = cyc;
  endtask

  task automatic count_ticks(input int ncyc, output int cnt);
    cnt = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (tick_o) cnt++;
    end
  endtask

  // hold, write parameters, pulse load, release; returns release edge
  task automatic prog_fresh(input logic [24:0] pw, output int rel);
    set_ctrl(1'b0, 1'b1, 1'b1);
    wr(1'b1, pw);
    set_ctrl(1'b1, 1'b1, 1'b1);
    set_ctrl(1'b0, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    set_ctrl(1'b0, 1'b1, 1'b0);
    rel = last_edge;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rel, t0, t1, t2, t3, t4, t5, n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8", tick_o, 0, "tick after reset");
    chk("R8", unprog_o, 1, "unprog after reset");
    count_ticks(20, n);
    chk("R6", n, 0, "pulses while hold is at reset value");

    // table of settings: first pulse latency and K-period span
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      longint one = lm(v.md, v.pe, v.sd, v.byp);
      prog_fresh(pword(v.md, v.pe, v.sd, v.byp), rel);
      chk("R7", unprog_o, 0, "unprog with a programmed set");
      wait_tick("R6", t0);
      chk("R6", t0 - rel, cdiv(one, 64'd1048576), "first pulse after release");
      for (int j = 0; j < int'(v.k); j++) wait_tick("R1", t1);
      chk(v.byp ? "R1" : "R2", t1 - t0,
          cdiv(one * (v.k + 1), 64'd1048576) - cdiv(one, 64'd1048576), "span of K periods");
    end

    // R3: parameter write alone is ignored (A: period 16, C: period 12)
    prog_fresh(pword(5'd0, 15'd0, 4'd4, 1'b1), rel);
    wait_tick("R3", t0);
    wr(1'b1, pword(5'd0, 15'd0, 4'd2, 1'b0));
    wait_tick("R3", t1);
    wait_tick("R3", t2);
    chk("R3", t2 - t1, 16, "period after write without load");
    set_ctrl(1'b1, 1'b1, 1'b0);
    wait_tick("R3", t3);
    wait_tick("R3", t4);
    wait_tick("R3", t5);
    chk("R3", t5 - t4, 12, "period after load rise");
    // load bit held high: a rewrite of 1 must not load D (period 8)
    wr(1'b1, pword(5'd0, 15'd0, 4'd3, 1'b1));
    set_ctrl(1'b1, 1'b1, 1'b0);
    wait_tick("R3", t0);
    wait_tick("R3", t1);
    wait_tick("R3", t2);
    chk("R3", t2 - t1, 12, "period with load held high");
    set_ctrl(1'b0, 1'b1, 1'b0);

    // R4: mid-period retune keeps the running period whole
    wait_tick("R4", t0);
    repeat (2) @(negedge clk);
    set_ctrl(1'b1, 1'b1, 1'b0);
    set_ctrl(1'b0, 1'b1, 1'b0);
    wait_tick("R4", t1);
    wait_tick("R4", t2);
    chk("R4", t1 - t0, 12, "period spanning the load");
    chk("R4", t2 - t1, 8, "first period of new set");

    // R5: standby freezes and resumes (period 8)
    wait_tick("R5", t0);
    set_ctrl(1'b0, 1'b0, 1'b0);
    t1 = last_edge;
    count_ticks(30, n);
    chk("R5", n, 0, "pulses in standby");
    set_ctrl(1'b0, 1'b1, 1'b0);
    t2 = last_edge;
    wait_tick("R5", t3);
    chk("R5", t3 - t0, 8 + (t2 - t1), "interval across standby");

    // R6: hold stops output
    set_ctrl(1'b0, 1'b1, 1'b1);
    count_ticks(30, n);
    chk("R6", n, 0, "pulses while held");

    // R7: all-zero set is unprogrammed and silent
    prog_fresh(pword(5'd0, 15'd0, 4'd0, 1'b1), rel);
    chk("R7", unprog_o, 1, "unprog flag with zero set");
    count_ticks(50, n);
    chk("R7", n, 0, "pulses when unprogrammed");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule